// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the architectural bookkeeping of a processor core when it takes one of two interrupts, and when it returns from the critical one. The first is a critical watchdog interrupt. The second is a precise, non-critical data translation miss. The core presents its current PC, its next sequential PC, its machine-state word and its vector prefix every cycle. It raises a one-cycle request for a watchdog time-out, for a translation miss, or for a return-from-critical command. The block saves state into the matching save-register pair. It records the faulting data address and a store syndrome bit on a miss. One cycle after accepting a request, it emits a single-cycle redirect carrying the new PC and the new machine state.

The translation lookup is outside the block. The miss request means that no valid entry matched the effective address together with the process ID. The block itself gates this request with the data-translation bit of the machine state.

Control is a four-state machine. `ST_IDLE` waits for a request. Acceptance moves it to `ST_WDOG`, `ST_DMISS` or `ST_RFCI`, and each of these drives the redirect for one cycle before the unconditional transition back to `ST_IDLE`. Requests that arrive while the machine is out of `ST_IDLE` are not accepted.

Machine-state bit positions, counted from bit 0 as the least significant bit:

| Bit | Meaning |
|---|---|
| 4 | data translation |
| 5 | instruction translation |
| 9 | debug enable |
| 10 | alternate watchdog enable |
| 12 | machine-check enable |
| 14 | user mode |
| 15 | external enable |
| 17 | critical enable |
| 18 | wait |

Top module: `isq_sequencer`

## Requirements
- R1: When a watchdog interrupt is accepted, the critical save-PC register takes `next_pc` and the critical save-state register takes `msr_in`, both on the accepting clock edge.
- R2: On the watchdog redirect, `msr_out` is the saved state with bits 18, 17, 15, 14, 10, 9, 5 and 4 cleared, and all other bits kept, including bit 12.
- R3: The redirect PC for an interrupt is the upper half of the captured `vec_prefix` joined to a low half of 0x1020 for the watchdog or 0x1100 for the miss.
- R4: An accepted return-from-critical command redirects to the critical save-PC with `msr_out` equal to the critical save-state.
- R5: A miss request is accepted only when `msr_in` bit 4 is set; otherwise it is ignored and the miss-related registers keep their values.
- R6: An accepted miss writes `cur_pc` into the non-critical save-PC and `msr_in` into the non-critical save-state.
- R7: An accepted miss writes `dmiss_addr` into the fault-address register.
- R8: An accepted miss sets the syndrome store bit to `dmiss_store` OR `dmiss_cbop` (block-zero and invalidate count as stores).
- R9: If both interrupts are accepted-eligible in one cycle, the watchdog wins. The priority order is watchdog, then miss, then return.
- R10: `redir_valid` is high for exactly one cycle, on the cycle after each accepted request; requests seen while it is high are not accepted.
- R11: After reset, every output is zero.
- R12: On the miss redirect, `msr_out` is the saved state with bits 18, 15, 14, 5 and 4 cleared and the other bits kept.
- R13: A watchdog request is accepted only when `msr_in` bit 17 (critical enable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cur_pc | input | ADDR_W | address of the instruction now executing |
| next_pc | input | ADDR_W | address of the next sequential instruction |
| msr_in | input | 32 | current machine-state word |
| vec_prefix | input | ADDR_W | vector prefix register; upper half used |
| wdog_req | input | 1 | watchdog time-out request |
| dmiss_req | input | 1 | data translation miss request |
| dmiss_addr | input | ADDR_W | data address that missed |
| dmiss_store | input | 1 | faulting operation is a store |
| dmiss_cbop | input | 1 | faulting operation is a block-zero or invalidate |
| rfci_req | input | 1 | return-from-critical command |
| redir_valid | output | 1 | one-cycle redirect pulse |
| redir_pc | output | ADDR_W | new PC, zero when no redirect |
| msr_out | output | 32 | new machine state, zero when no redirect |
| crit_save_pc | output | ADDR_W | critical save-PC register |
| crit_save_msr | output | 32 | critical save-state register |
| ncrit_save_pc | output | ADDR_W | non-critical save-PC register |
| ncrit_save_msr | output | 32 | non-critical save-state register |
| fault_addr | output | ADDR_W | fault-address register |
| synd_store | output | 1 | syndrome store bit |

## Verification
The assertions assume the core presents the inputs they reference stably around each rising edge. They also assume the core treats a request raised during the redirect cycle as lost, so the properties only claim acceptance when `redir_valid` is low. The bench drives every input on the falling edge and holds it for a full cycle. Its directed scenarios and a random phase draw requests independently, so collisions and requests during a redirect occur as well. The behavioural model applies the same idle-only acceptance rule.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int MSR_W = 32;

    // Machine-state bit positions (bit 0 = least significant)
    localparam int MS_DTRANS   = 4;
    localparam int MS_ITRANS   = 5;
    localparam int MS_DBG_EN   = 9;
    localparam int MS_ALTWD_EN = 10;
    localparam int MS_MCHK_EN  = 12;
    localparam int MS_USER     = 14;
    localparam int MS_EXT_EN   = 15;
    localparam int MS_CRIT_EN  = 17;
    localparam int MS_WAIT     = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDOG  = 2'd1,
        ST_DMISS = 2'd2,
        ST_RFCI  = 2'd3
    } isq_state_e;

    function automatic logic [MSR_W-1:0] bit_at(input int pos);
        logic [MSR_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

    // Bits cleared on critical (watchdog) entry
    localparam logic [MSR_W-1:0] CRIT_CLR =
        bit_at(MS_WAIT) | bit_at(MS_CRIT_EN) | bit_at(MS_EXT_EN) |
        bit_at(MS_USER) | bit_at(MS_DBG_EN) | bit_at(MS_ALTWD_EN) |
        bit_at(MS_ITRANS) | bit_at(MS_DTRANS);

    // Bits cleared on non-critical (miss) entry
    localparam logic [MSR_W-1:0] NCRIT_CLR =
        bit_at(MS_WAIT) | bit_at(MS_EXT_EN) | bit_at(MS_USER) |
        bit_at(MS_ITRANS) | bit_at(MS_DTRANS);

endpackage

// File: rtl/isq_arbiter.sv
module isq_arbiter
    import isq_pkg::*;
(
    input  logic       wdog_req,
    input  logic       crit_en,
    input  logic       dmiss_req,
    input  logic       dtrans_en,
    input  logic       rfci_req,
    output isq_state_e pick
);

    logic wdog_ok;
    logic dmiss_ok;

    assign wdog_ok  = wdog_req & crit_en;
    assign dmiss_ok = dmiss_req & dtrans_en;

    // Fixed priority: watchdog, then miss, then return
    always_comb begin
        if (wdog_ok) begin
            pick = ST_WDOG;
        end else if (dmiss_ok) begin
            pick = ST_DMISS;
        end else if (rfci_req) begin
            pick = ST_RFCI;
        end else begin
            pick = ST_IDLE;
        end
    end

endmodule

// File: rtl/isq_fsm.sv
module isq_fsm
    import isq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  isq_state_e pick,
    output isq_state_e state_q,
    output logic       cap_wdog,
    output logic       cap_dmiss
);

    isq_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = pick;
            ST_WDOG:  state_d = ST_IDLE;
            ST_DMISS: state_d = ST_IDLE;
            ST_RFCI:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cap_wdog  = (state_q == ST_IDLE) && (state_d == ST_WDOG);
        cap_dmiss = (state_q == ST_IDLE) && (state_d == ST_DMISS);
    end

endmodule

// File: rtl/isq_save_pair.sv
module isq_save_pair
    import isq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [MSR_W-1:0]  msr_in,
    output logic [ADDR_W-1:0] pc_q,
    output logic [MSR_W-1:0]  msr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            msr_q <= '0;
        end else if (cap) begin
            pc_q  <= pc_in;
            msr_q <= msr_in;
        end
    end

endmodule

// File: rtl/isq_redirect.sv
module isq_redirect
    import isq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WDOG_OFF  = 'h1020,
    parameter int DMISS_OFF = 'h1100
) (
    input  isq_state_e        state,
    input  logic [ADDR_W-1:0] vec_q,
    input  logic [ADDR_W-1:0] crit_pc,
    input  logic [MSR_W-1:0]  crit_msr,
    input  logic [MSR_W-1:0]  ncrit_msr,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc,
    output logic [MSR_W-1:0]  msr_out
);

    localparam int HALF_W = ADDR_W / 2;
    localparam int UP_W   = ADDR_W - HALF_W;
    localparam logic [ADDR_W-1:0] HI_MASK  = {{UP_W{1'b1}}, {HALF_W{1'b0}}};
    localparam logic [ADDR_W-1:0] WDOG_LO  = {{UP_W{1'b0}}, HALF_W'(WDOG_OFF)};
    localparam logic [ADDR_W-1:0] DMISS_LO = {{UP_W{1'b0}}, HALF_W'(DMISS_OFF)};

    logic [ADDR_W-1:0] vec_hi;
    assign vec_hi = vec_q & HI_MASK;

    always_comb begin
        unique case (state)
            ST_IDLE: begin
                redir_valid = 1'b0;
                redir_pc    = '0;
                msr_out     = '0;
            end
            ST_WDOG: begin
                redir_valid = 1'b1;
                redir_pc    = vec_hi | WDOG_LO;
                msr_out     = crit_msr & ~CRIT_CLR;
            end
            ST_DMISS: begin
                redir_valid = 1'b1;
                redir_pc    = vec_hi | DMISS_LO;
                msr_out     = ncrit_msr & ~NCRIT_CLR;
            end
            ST_RFCI: begin
                redir_valid = 1'b1;
                redir_pc    = crit_pc;
                msr_out     = crit_msr;
            end
            default: begin
                redir_valid = 1'b0;
                redir_pc    = '0;
                msr_out     = '0;
            end
        endcase
    end

endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
    import isq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WDOG_OFF  = 'h1020,
    parameter int DMISS_OFF = 'h1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [MSR_W-1:0]  msr_in,
    input  logic [ADDR_W-1:0] vec_prefix,
    input  logic              wdog_req,
    input  logic              dmiss_req,
    input  logic [ADDR_W-1:0] dmiss_addr,
    input  logic              dmiss_store,
    input  logic              dmiss_cbop,
    input  logic              rfci_req,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc,
    output logic [MSR_W-1:0]  msr_out,
    output logic [ADDR_W-1:0] crit_save_pc,
    output logic [MSR_W-1:0]  crit_save_msr,
    output logic [ADDR_W-1:0] ncrit_save_pc,
    output logic [MSR_W-1:0]  ncrit_save_msr,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              synd_store
);

    localparam int N_PAIR = 2;   // index 0: critical, index 1: non-critical

    isq_state_e pick;
    isq_state_e state_q;
    logic       cap_wdog;
    logic       cap_dmiss;
    logic [ADDR_W-1:0] vec_q;

    isq_arbiter u_arb (
        .wdog_req  (wdog_req),
        .crit_en   (msr_in[MS_CRIT_EN]),
        .dmiss_req (dmiss_req),
        .dtrans_en (msr_in[MS_DTRANS]),
        .rfci_req  (rfci_req),
        .pick      (pick)
    );

    isq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick      (pick),
        .state_q   (state_q),
        .cap_wdog  (cap_wdog),
        .cap_dmiss (cap_dmiss)
    );

    logic [N_PAIR-1:0]             pair_cap;
    logic [N_PAIR-1:0][ADDR_W-1:0] pair_pc_in;
    logic [N_PAIR-1:0][ADDR_W-1:0] pair_pc_q;
    logic [N_PAIR-1:0][MSR_W-1:0]  pair_msr_q;

    assign pair_cap[0]   = cap_wdog;
    assign pair_pc_in[0] = next_pc;   // critical: next sequential instruction
    assign pair_cap[1]   = cap_dmiss;
    assign pair_pc_in[1] = cur_pc;    // precise: faulting instruction

    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        isq_save_pair #(.ADDR_W(ADDR_W)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap    (pair_cap[g]),
            .pc_in  (pair_pc_in[g]),
            .msr_in (msr_in),
            .pc_q   (pair_pc_q[g]),
            .msr_q  (pair_msr_q[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q      <= '0;
            fault_addr <= '0;
            synd_store <= 1'b0;
        end else begin
            if (cap_wdog || cap_dmiss) begin
                vec_q <= vec_prefix;
            end
            if (cap_dmiss) begin
                fault_addr <= dmiss_addr;
                synd_store <= dmiss_store | dmiss_cbop;
            end
        end
    end

    isq_redirect #(
        .ADDR_W    (ADDR_W),
        .WDOG_OFF  (WDOG_OFF),
        .DMISS_OFF (DMISS_OFF)
    ) u_red (
        .state       (state_q),
        .vec_q       (vec_q),
        .crit_pc     (pair_pc_q[0]),
        .crit_msr    (pair_msr_q[0]),
        .ncrit_msr   (pair_msr_q[1]),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .msr_out     (msr_out)
    );

    assign crit_save_pc   = pair_pc_q[0];
    assign crit_save_msr  = pair_msr_q[0];
    assign ncrit_save_pc  = pair_pc_q[1];
    assign ncrit_save_msr = pair_msr_q[1];

endmodule

// File: rtl/isq_sequencer_chk.sv
module isq_sequencer_chk
    import isq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WDOG_OFF  = 'h1020,
    parameter int DMISS_OFF = 'h1100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic [MSR_W-1:0]  msr_in,
    input logic              wdog_req,
    input logic              dmiss_req,
    input logic [ADDR_W-1:0] dmiss_addr,
    input logic              rfci_req,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_pc,
    input logic [MSR_W-1:0]  msr_out,
    input logic [ADDR_W-1:0] crit_save_pc,
    input logic [MSR_W-1:0]  crit_save_msr,
    input logic [ADDR_W-1:0] ncrit_save_pc,
    input logic [ADDR_W-1:0] fault_addr
);

    localparam int HALF_W = ADDR_W / 2;

    logic wd_ok;
    logic dm_ok;
    assign wd_ok = wdog_req & msr_in[MS_CRIT_EN];
    assign dm_ok = dmiss_req & msr_in[MS_DTRANS];

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R1
    crit_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && wd_ok) |=>
            (crit_save_pc == $past(next_pc)) && (crit_save_msr == $past(msr_in)));

    // R2
    crit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && wd_ok) |=>
            ((msr_out & CRIT_CLR) == '0) &&
            (msr_out[MS_MCHK_EN] == $past(msr_in[MS_MCHK_EN])));

    // R3
    wdog_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && wd_ok) |=>
            redir_valid && (redir_pc[HALF_W-1:0] == HALF_W'(WDOG_OFF)));

    // R9
    miss_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !wd_ok && dm_ok) |=>
            redir_valid && (redir_pc[HALF_W-1:0] == HALF_W'(DMISS_OFF)));

    // R6
    miss_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !wd_ok && dm_ok) |=>
            (ncrit_save_pc == $past(cur_pc)) && (fault_addr == $past(dmiss_addr)));

    // R5
    miss_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !wdog_req && !rfci_req && dmiss_req && !msr_in[MS_DTRANS]) |=>
            !redir_valid && $stable(fault_addr));

    // R4
    rfci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !wd_ok && !dm_ok && rfci_req) |=>
            redir_valid && (redir_pc == $past(crit_save_pc)) &&
            (msr_out == $past(crit_save_msr)));

endmodule

bind isq_sequencer isq_sequencer_chk #(
    .ADDR_W    (ADDR_W),
    .WDOG_OFF  (WDOG_OFF),
    .DMISS_OFF (DMISS_OFF)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_pc        (cur_pc),
    .next_pc       (next_pc),
    .msr_in        (msr_in),
    .wdog_req      (wdog_req),
    .dmiss_req     (dmiss_req),
    .dmiss_addr    (dmiss_addr),
    .rfci_req      (rfci_req),
    .redir_valid   (redir_valid),
    .redir_pc      (redir_pc),
    .msr_out       (msr_out),
    .crit_save_pc  (crit_save_pc),
    .crit_save_msr (crit_save_msr),
    .ncrit_save_pc (ncrit_save_pc),
    .fault_addr    (fault_addr)
);

// File: tb/sim_isq_sequencer.sv
`timescale 1ns/1ps
module sim_isq_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, next_pc = '0, msr_in = '0, vec_prefix = '0, dmiss_addr = '0;
    logic        wdog_req = 1'b0, dmiss_req = 1'b0, dmiss_store = 1'b0, dmiss_cbop = 1'b0;
    logic        rfci_req = 1'b0;
    logic        redir_valid, synd_store;
    logic [31:0] redir_pc, msr_out, crit_save_pc, crit_save_msr;
    logic [31:0] ncrit_save_pc, ncrit_save_msr, fault_addr;

    always #2.5 clk = ~clk;

    isq_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .next_pc(next_pc),
        .msr_in(msr_in), .vec_prefix(vec_prefix), .wdog_req(wdog_req),
        .dmiss_req(dmiss_req), .dmiss_addr(dmiss_addr), .dmiss_store(dmiss_store),
        .dmiss_cbop(dmiss_cbop), .rfci_req(rfci_req), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .msr_out(msr_out), .crit_save_pc(crit_save_pc),
        .crit_save_msr(crit_save_msr), .ncrit_save_pc(ncrit_save_pc),
        .ncrit_save_msr(ncrit_save_msr), .fault_addr(fault_addr),
        .synd_store(synd_store)
    );

    // Bit clear sets from the requirements (R2, R12)
    localparam logic [31:0] WD_CLR = 32'h0006_C630;
    localparam logic [31:0] NC_CLR = 32'h0004_C030;

    int checks = 0;
    int errors = 0;
    string tag = "R11";
    bit done = 1'b0;
    int cyc = 0;

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] got %h exp %h", what, tag, got, exp);
        end
    endtask

    // Behavioural reference model
    int          m_kind = 0;          // 0 none, 1 watchdog, 2 miss, 3 return
    logic [31:0] m_cpc = 0, m_cmsr = 0, m_npc = 0, m_nmsr = 0, m_dear = 0, m_vec = 0;
    logic        m_syn = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_kind = 0; m_cpc = 0; m_cmsr = 0; m_npc = 0; m_nmsr = 0;
            m_dear = 0; m_vec = 0; m_syn = 0;
        end else if (m_kind != 0) begin
            m_kind = 0;
        end else if (wdog_req && msr_in[17]) begin
            m_cpc = next_pc; m_cmsr = msr_in; m_vec = vec_prefix; m_kind = 1;
        end else if (dmiss_req && msr_in[4]) begin
            m_npc = cur_pc; m_nmsr = msr_in; m_dear = dmiss_addr;
            m_syn = dmiss_store || dmiss_cbop; m_vec = vec_prefix; m_kind = 2;
        end else if (rfci_req) begin
            m_kind = 3;
        end
    end

    always @(negedge clk) begin
        logic [31:0] e_pc, e_msr;
        if (rst_n) begin
            case (m_kind)
                1: begin e_pc = {m_vec[31:16], 16'h1020}; e_msr = m_cmsr & ~WD_CLR; end
                2: begin e_pc = {m_vec[31:16], 16'h1100}; e_msr = m_nmsr & ~NC_CLR; end
                3: begin e_pc = m_cpc; e_msr = m_cmsr; end
                default: begin e_pc = 0; e_msr = 0; end
            endcase
            chk("R10 redir_valid", {31'b0, redir_valid}, {31'b0, m_kind != 0});
            chk("R3 redir_pc", redir_pc, e_pc);
            chk("R2 msr_out", msr_out, e_msr);
            chk("R1 crit_save_pc", crit_save_pc, m_cpc);
            chk("R1 crit_save_msr", crit_save_msr, m_cmsr);
            chk("R6 ncrit_save_pc", ncrit_save_pc, m_npc);
            chk("R6 ncrit_save_msr", ncrit_save_msr, m_nmsr);
            chk("R7 fault_addr", fault_addr, m_dear);
            chk("R8 synd_store", {31'b0, synd_store}, {31'b0, m_syn});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL R10 watchdog expired got %0d exp <20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear_in();
        wdog_req = 0; dmiss_req = 0; rfci_req = 0; dmiss_store = 0; dmiss_cbop = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R11";
        chk("R11 reset redir_valid", {31'b0, redir_valid}, 32'h0);
        chk("R11 reset redir_pc", redir_pc, 32'h0);
        chk("R11 reset fault_addr", fault_addr, 32'h0);
        chk("R11 reset crit_save_pc", crit_save_pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Watchdog entry, all state bits set
        tag = "R2";
        msr_in = 32'hFFFF_FFFF; vec_prefix = 32'hABCD_5555; next_pc = 32'h0000_2004;
        cur_pc = 32'h0000_2000; wdog_req = 1;
        @(negedge clk); clear_in();
        chk("R3 wdog pc", redir_pc, 32'hABCD_1020);
        chk("R2 wdog msr", msr_out, 32'hFFF9_39CF);
        @(negedge clk);

        // Watchdog without critical enable is ignored
        tag = "R13";
        msr_in = 32'h0000_1010; wdog_req = 1;
        @(negedge clk); clear_in();
        chk("R13 no redirect", {31'b0, redir_valid}, 32'h0);
        @(negedge clk);

        // Return from critical
        tag = "R4";
        rfci_req = 1;
        @(negedge clk); clear_in();
        chk("R4 rfci pc", redir_pc, 32'h0000_2004);
        chk("R4 rfci msr", msr_out, 32'hFFFF_FFFF);
        @(negedge clk);

        // Misses: load, store, block op
        tag = "R12";
        msr_in = 32'h0006_D23F; vec_prefix = 32'h1234_0000; cur_pc = 32'h0000_4440;
        dmiss_addr = 32'hDEAD_BEE0; dmiss_req = 1;
        @(negedge clk); clear_in();
        chk("R12 miss msr", msr_out, 32'h0002_120F);
        chk("R8 load syndrome", {31'b0, synd_store}, 32'h0);
        @(negedge clk);
        tag = "R8";
        dmiss_req = 1; dmiss_store = 1; dmiss_addr = 32'h0000_0100;
        @(negedge clk); clear_in();
        chk("R8 store syndrome", {31'b0, synd_store}, 32'h1);
        @(negedge clk);
        dmiss_req = 1; dmiss_cbop = 1;
        @(negedge clk); clear_in();
        chk("R8 cbop syndrome", {31'b0, synd_store}, 32'h1);
        @(negedge clk);

        // Miss with translation off is ignored
        tag = "R5";
        msr_in = 32'h0002_0000; dmiss_req = 1; dmiss_addr = 32'h5555_0000;
        @(negedge clk); clear_in();
        chk("R5 no redirect", {31'b0, redir_valid}, 32'h0);
        chk("R5 fault_addr kept", fault_addr, 32'h0000_0100);
        @(negedge clk);

        // Collision: watchdog wins
        tag = "R9";
        msr_in = 32'h0002_0010; wdog_req = 1; dmiss_req = 1; dmiss_addr = 32'h7777_0000;
        @(negedge clk); clear_in();
        chk("R9 watchdog first", redir_pc[15:0], 32'h1020);
        chk("R9 miss not recorded", fault_addr, 32'h0000_0100);
        @(negedge clk);

        // Random phase, compared each cycle by the model
        tag = "R10";
        for (int i = 0; i < 2000; i++) begin
            wdog_req    = ($urandom % 6) == 0;
            dmiss_req   = ($urandom % 4) == 0;
            rfci_req    = ($urandom % 5) == 0;
            dmiss_store = $urandom;
            dmiss_cbop  = ($urandom % 3) == 0;
            msr_in      = $urandom;
            cur_pc      = $urandom;
            next_pc     = $urandom;
            vec_prefix  = $urandom;
            dmiss_addr  = $urandom;
            @(negedge clk);
        end
        clear_in();
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule